// File: doc/BRIEF.md
# Event-Sequenced State Timer

This block is a counter/timer whose outputs, interrupt and counter control are not tied to fixed match actions. A table of eight programmable events is evaluated every clock cycle. Each event looks at a counter comparison, at a level or edge on one input or output pin, or at both together. A small state register picks which events are live: every event holds one enable bit per state value. An event that fires can drive outputs high or low, pulse the interrupt, start, stop or clear the counter, and move the state register to a new value. That new value selects a different set of live events from the next cycle on.

Software fills in the event table, the per-state enables, the match values and the control word through a simple write port. After that the block runs on its own. Chains of state changes produce output waveforms and interrupt sequences with no further register traffic. With a single state in use, it acts as a plain event-driven up or up/down counter.

Top module: `evt_state_timer`

## Requirements
- R1: After reset, all outputs, the interrupt, the state register and the counter are 0, the counter is stopped, all match values and event settings are 0 and no event is enabled in any state.
- R2: In up mode (control bit 8 clear), a running counter increments once per clock and returns to 0 on the clock after it has reached match register 0, which acts as the limit.
- R3: In up/down mode (control bit 8 set), a running counter rises to the limit, then falls one per clock to 0, then rises again.
- R4: The combine field of an event (bits 8:7) selects 0 = match only (the counter equals the match register named by bits 1:0), 1 = pin condition only, 2 = both together, 3 = never.
- R5: The pin condition (bits 6:5) is 0 = low, 1 = high, 2 = rising, 3 = falling, on pin bits 3:2 of the inputs (bit 4 clear) or of the outputs (bit 4 set). Inputs pass two synchronizing flops, so an action caused by an input edge takes effect on the third clock edge after the pin changes.
- R6: An event acts only while bit s of its state mask is set, where s is the current state value. Otherwise it has no effect at all.
- R7: The actions of all events that fire in one cycle are ORed. Output changes and the interrupt take effect on the next clock edge, and the interrupt is high for one cycle for each cycle in which an event carrying interrupt fires.
- R8: An output that is asked to be set (event bits 12:9) and cleared (bits 16:13) in the same cycle follows control field bits 2o+1:2o: 0 = hold, 1 = set, 2 = clear, 3 = toggle.
- R9: Event bit 18 starts the counter, bit 19 stops it and stop wins over start, and bit 20 returns the count to 0 and the direction to up on the next edge while leaving run/stop unchanged.
- R10: Event bit 21 loads bits 25:22 into the state register on the next edge. When several events load in the same cycle, the highest-numbered one wins. With no load, the state holds.
- R11: Write addresses are: match register k at k (0..3), event e config at 8+e, event e state mask at 16+e, control at 24 (bits 7:0 conflict settings, bit 8 up/down, bit 9 run). Match flag k is high while the count equals match register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration write address |
| cfgWdata | input | 26 | Configuration write data |
| pinIn | input | 4 | Asynchronous input pins |
| pinOut | output | 4 | Output pins |
| irq | output | 1 | Interrupt pulse |
| matchFlags | output | 4 | Count equals match register k |
| countOut | output | CNT_W | Current count |
| stateOut | output | 4 | Current state register |

## Verification
The bench builds the block with eight events, a 4-bit state and four match registers, as in the defaults, and sets the counter width to 8. Short limits such as 3 then show up-mode wrap and the up/down turn-around inside a handful of cycles. The narrow state field lets a single scenario walk through several states, so the state gating, the OR merge of actions, the conflict settings and the load priority can be checked on exact edges. Edge-triggered start, stop and clear are timed against the two-flop input path, so that an extra or a missing synchronizer stage shows up as a one-cycle shift in the count.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int N_EVT     = 8;
  localparam int ST_W      = 4;
  localparam int N_ST      = 1 << ST_W;
  localparam int N_OUT     = 4;
  localparam int N_IN      = 4;
  localparam int N_MATCH   = 4;
  localparam int MSEL_W    = $clog2(N_MATCH);
  localparam int PIN_W     = $clog2((N_IN > N_OUT) ? N_IN : N_OUT);
  localparam int ADDR_W    = 5;
  localparam int ADR_MATCH = 0;
  localparam int ADR_EVT   = 8;
  localparam int ADR_MASK  = 16;
  localparam int ADR_CTRL  = 24;
  localparam int CTRL_BIDIR = 2 * N_OUT;
  localparam int CTRL_RUN   = 2 * N_OUT + 1;
  localparam int CTRL_W     = 2 * N_OUT + 2;

  typedef enum logic [1:0] {IO_LOW, IO_HIGH, IO_RISE, IO_FALL} ioCond_e;
  typedef enum logic [1:0] {CMB_MATCH, CMB_IO, CMB_AND, CMB_OFF} combine_e;

  typedef struct packed {
    logic [ST_W-1:0]   nextState;
    logic              loadState;
    logic              doReset;
    logic              doStop;
    logic              doStart;
    logic              doIrq;
    logic [N_OUT-1:0]  clrMask;
    logic [N_OUT-1:0]  setMask;
    combine_e          combine;
    ioCond_e           ioCond;
    logic              ioIsOut;
    logic [PIN_W-1:0]  pinSel;
    logic [MSEL_W-1:0] matchSel;
  } evtCfg_t;

  localparam int EVT_CFG_W = $bits(evtCfg_t);
  localparam int DATA_W    = EVT_CFG_W;

  typedef struct packed {
    logic [N_OUT-1:0] setMask;
    logic [N_OUT-1:0] clrMask;
    logic             irq;
    logic             start;
    logic             stop;
    logic             rst;
    logic             stLoad;
    logic [ST_W-1:0]  stNext;
  } strobe_t;
endpackage

// File: rtl/evt_dp.sv
module evt_dp
  import evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WD_W  = CTRL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [WD_W-1:0]    cfgWdata,
  input  strobe_t            stb,
  input  logic [N_IN-1:0]    pinIn,
  output logic [N_OUT-1:0]   pinOut,
  output logic               irq,
  output logic [CNT_W-1:0]   count,
  output logic [N_MATCH-1:0] matchHit,
  output logic [ST_W-1:0]    curState,
  output logic [N_IN-1:0]    inCur,
  output logic [N_IN-1:0]    inOld,
  output logic [N_OUT-1:0]   outOld
);
  logic [CNT_W-1:0]   matchReg [N_MATCH];
  logic [2*N_OUT-1:0] resolve;
  logic               bidir;
  logic               running;
  logic               dirDown;
  logic [N_IN-1:0]    inMeta;
  logic [CNT_W-1:0]   cntNext;
  logic               dirNext;
  logic [N_OUT-1:0]   outNext;
  logic [CNT_W-1:0]   lim;
  logic               ctrlWr;

  assign ctrlWr = cfgWe && (cfgAddr == ADDR_W'(ADR_CTRL));
  assign lim    = matchReg[0];

  // match registers and their comparators
  for (genvar k = 0; k < N_MATCH; k++) begin : gMatch
    always_ff @(posedge clk) begin
      if (!rstN) matchReg[k] <= '0;
      else if (cfgWe && cfgAddr == ADDR_W'(ADR_MATCH + k))
        matchReg[k] <= cfgWdata[CNT_W-1:0];
    end
    assign matchHit[k] = (count == matchReg[k]);
  end

  // control word and run flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resolve <= '0;
      bidir   <= 1'b0;
      running <= 1'b0;
    end else begin
      if (ctrlWr) begin
        resolve <= cfgWdata[2*N_OUT-1:0];
        bidir   <= cfgWdata[CTRL_BIDIR];
        running <= cfgWdata[CTRL_RUN];
      end else if (stb.stop) begin
        running <= 1'b0;
      end else if (stb.start) begin
        running <= 1'b1;
      end
    end
  end

  // counter next value
  always_comb begin
    cntNext = count;
    dirNext = dirDown;
    if (stb.rst) begin
      cntNext = '0;
      dirNext = 1'b0;
    end else if (running) begin
      if (!bidir) begin
        dirNext = 1'b0;
        cntNext = (count >= lim) ? '0 : count + 1'b1;
      end else if (!dirDown) begin
        if (count >= lim) begin
          dirNext = (count != '0);
          cntNext = (count == '0) ? count : count - 1'b1;
        end else begin
          cntNext = count + 1'b1;
        end
      end else begin
        if (count == '0) begin
          dirNext = 1'b0;
          cntNext = (lim == '0) ? count : count + 1'b1;
        end else begin
          cntNext = count - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      dirDown <= 1'b0;
    end else begin
      count   <= cntNext;
      dirDown <= dirNext;
    end
  end

  // per-output merge of set and clear requests
  for (genvar o = 0; o < N_OUT; o++) begin : gOut
    always_comb begin
      outNext[o] = pinOut[o];
      if (stb.setMask[o] && stb.clrMask[o]) begin
        case (resolve[2*o +: 2])
          2'd1:    outNext[o] = 1'b1;
          2'd2:    outNext[o] = 1'b0;
          2'd3:    outNext[o] = ~pinOut[o];
          default: outNext[o] = pinOut[o];
        endcase
      end else if (stb.setMask[o]) begin
        outNext[o] = 1'b1;
      end else if (stb.clrMask[o]) begin
        outNext[o] = 1'b0;
      end
    end
  end

  // pins, state and interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMeta   <= '0;
      inCur    <= '0;
      inOld    <= '0;
      pinOut   <= '0;
      outOld   <= '0;
      curState <= '0;
      irq      <= 1'b0;
    end else begin
      inMeta   <= pinIn;
      inCur    <= inMeta;
      inOld    <= inCur;
      pinOut   <= outNext;
      outOld   <= pinOut;
      if (stb.stLoad) curState <= stb.stNext;
      irq      <= stb.irq;
    end
  end

  assert_state_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stLoad |=> $stable(curState));
  assert_state_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.stLoad |=> curState == $past(stb.stNext));
  assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask == '0 && stb.clrMask == '0) |=> $stable(pinOut));
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.rst |=> count == '0);
  assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stop && !ctrlWr) |=> !running);
endmodule

// File: rtl/evt_ctl.sv
module evt_ctl
  import evt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic [N_MATCH-1:0] matchHit,
  input  logic [N_IN-1:0]    inCur,
  input  logic [N_IN-1:0]    inOld,
  input  logic [N_OUT-1:0]   outCur,
  input  logic [N_OUT-1:0]   outOld,
  input  logic [ST_W-1:0]    curState,
  output strobe_t            stb
);
  evtCfg_t          cfg    [N_EVT];
  logic [N_ST-1:0]  stMask [N_EVT];
  logic [N_EVT-1:0] enVec;
  logic [N_EVT-1:0] fire;

  for (genvar e = 0; e < N_EVT; e++) begin : gEvt
    logic mHit, lvl, old, ioHit, condOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfg[e]    <= '0;
        stMask[e] <= '0;
      end else if (cfgWe) begin
        if (cfgAddr == ADDR_W'(ADR_EVT + e))
          cfg[e] <= evtCfg_t'(cfgWdata[EVT_CFG_W-1:0]);
        if (cfgAddr == ADDR_W'(ADR_MASK + e))
          stMask[e] <= cfgWdata[N_ST-1:0];
      end
    end

    always_comb begin
      mHit = matchHit[cfg[e].matchSel];
      lvl  = cfg[e].ioIsOut ? outCur[cfg[e].pinSel] : inCur[cfg[e].pinSel];
      old  = cfg[e].ioIsOut ? outOld[cfg[e].pinSel] : inOld[cfg[e].pinSel];
      case (cfg[e].ioCond)
        IO_LOW:  ioHit = ~lvl;
        IO_HIGH: ioHit = lvl;
        IO_RISE: ioHit = lvl & ~old;
        default: ioHit = ~lvl & old;
      endcase
      case (cfg[e].combine)
        CMB_MATCH: condOk = mHit;
        CMB_IO:    condOk = ioHit;
        CMB_AND:   condOk = mHit & ioHit;
        default:   condOk = 1'b0;
      endcase
    end

    assign enVec[e] = stMask[e][curState];
    assign fire[e]  = enVec[e] & condOk;
  end

  // OR all actions; ascending walk lets the highest event own the state load
  always_comb begin
    stb = '0;
    for (int e = 0; e < N_EVT; e++) begin
      if (fire[e]) begin
        stb.setMask = stb.setMask | cfg[e].setMask;
        stb.clrMask = stb.clrMask | cfg[e].clrMask;
        stb.irq     = stb.irq   | cfg[e].doIrq;
        stb.start   = stb.start | cfg[e].doStart;
        stb.stop    = stb.stop  | cfg[e].doStop;
        stb.rst     = stb.rst   | cfg[e].doReset;
        if (cfg[e].loadState) begin
          stb.stLoad = 1'b1;
          stb.stNext = cfg[e].nextState;
        end
      end
    end
  end

  assert_gated_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0) |-> (stb == '0));
endmodule

// File: rtl/evt_state_timer.sv
module evt_state_timer
  import evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic [N_IN-1:0]    pinIn,
  output logic [N_OUT-1:0]   pinOut,
  output logic               irq,
  output logic [N_MATCH-1:0] matchFlags,
  output logic [CNT_W-1:0]   countOut,
  output logic [ST_W-1:0]    stateOut
);
  localparam int DP_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W;

  strobe_t          stb;
  logic [N_IN-1:0]  inCur, inOld;
  logic [N_OUT-1:0] outOld;

  evt_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .matchHit(matchFlags), .inCur(inCur), .inOld(inOld), .outCur(pinOut),
    .outOld(outOld), .curState(stateOut), .stb(stb)
  );

  evt_dp #(.CNT_W(CNT_W), .WD_W(DP_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata[DP_W-1:0]), .stb(stb), .pinIn(pinIn),
    .pinOut(pinOut), .irq(irq), .count(countOut), .matchHit(matchFlags),
    .curState(stateOut), .inCur(inCur), .inOld(inOld), .outOld(outOld)
  );
endmodule

// File: tb/sim_evt_state_timer.sv
module sim_evt_state_timer;
  import evt_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  // vector: {combine[1:0], cond[1:0], matchEq, pinBefore, pinAfter, expectOut0}
  localparam logic [7:0] VEC [0:12] = '{
    8'b00_00_1_0_0_1, 8'b00_00_0_0_0_0,
    8'b01_01_0_0_1_1, 8'b01_01_0_0_0_0,
    8'b01_00_0_1_1_0, 8'b01_00_0_1_0_1,
    8'b01_10_0_0_1_1, 8'b01_10_0_1_0_0,
    8'b01_11_0_1_0_1, 8'b01_11_0_0_1_0,
    8'b10_01_1_0_1_1, 8'b10_01_0_0_1_0,
    8'b11_01_1_0_1_0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [DATA_W-1:0] cfgWdata = '0;
  logic [N_IN-1:0] pinIn = '0;
  logic [N_OUT-1:0] pinOut;
  logic irq;
  logic [N_MATCH-1:0] matchFlags;
  logic [CW-1:0] countOut;
  logic [ST_W-1:0] stateOut;
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_state_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .pinIn(pinIn), .pinOut(pinOut), .irq(irq), .matchFlags(matchFlags),
    .countOut(countOut), .stateOut(stateOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mkEvt(
    input logic [1:0] msel, input logic [1:0] pin, input logic isOut,
    input logic [1:0] cond, input logic [1:0] comb,
    input logic [3:0] setM, input logic [3:0] clrM,
    input logic doIrq, input logic doStart, input logic doStop, input logic doRst,
    input logic ld, input logic [3:0] ns);
    return {ns, ld, doRst, doStop, doStart, doIrq, clrM, setM, comb, cond, isOut, pin, msel};
  endfunction

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    cfgWe = 1'b1; cfgAddr = ADDR_W'(a); cfgWdata = d;
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doReset(input logic [N_IN-1:0] pins);
    @(negedge clk);
    rstN = 1'b0; pinIn = pins;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R1 and R11: reset state
    doReset('0);
    check("R1 outputs", pinOut, 0);
    check("R1 irq", irq, 0);
    check("R1 state", stateOut, 0);
    check("R1 count", countOut, 0);
    check("R11 flags after reset", matchFlags, 4'hf);
    idle(3);
    check("R1 counter stopped", countOut, 0);
    wr(ADR_MATCH + 3, 7);
    check("R11 match3 written", matchFlags, 4'h7);

    // R4 / R5 table of event conditions
    for (int v = 0; v < 13; v++) begin
      doReset({3'b0, VEC[v][2]});
      idle(5);
      wr(ADR_MATCH + 1, VEC[v][3] ? 0 : 5);
      wr(ADR_EVT + 0, mkEvt(2'd1, 2'd0, 1'b0, VEC[v][5:4], VEC[v][7:6],
                            4'b0001, 4'b0, 0, 0, 0, 0, 0, 4'd0));
      wr(ADR_MASK + 0, 1);
      idle(4);
      pinIn[0] = VEC[v][1];
      idle(5);
      check($sformatf("R4 R5 vector %0d", v), pinOut[0], VEC[v][0]);
    end

    // R2 up count with wrap at limit 3
    doReset('0);
    wr(ADR_MATCH + 0, 3);
    wr(ADR_CTRL, 1 << CTRL_RUN);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2 up count", countOut, (i + 1) % 4);
    end

    // R3 up/down with limit 3
    doReset('0);
    wr(ADR_MATCH + 0, 3);
    wr(ADR_CTRL, (1 << CTRL_RUN) | (1 << CTRL_BIDIR));
    begin
      int seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        check("R3 up/down count", countOut, seq[i]);
      end
    end

    // R6 R7 R8 R10: state walk; conflict: out0 toggle, out1 hold, out2 clear, out3 set
    doReset('0);
    wr(ADR_CTRL, 'h63);
    wr(ADR_MATCH + 1, 0);
    wr(ADR_EVT + 0, mkEvt(1, 0, 0, 0, 0, 4'b0010, 0, 0, 0, 0, 0, 1, 4'd3));
    wr(ADR_EVT + 1, mkEvt(1, 0, 0, 0, 0, 4'b0100, 0, 0, 0, 0, 0, 0, 4'd0));
    wr(ADR_EVT + 2, mkEvt(1, 0, 0, 0, 0, 4'b1111, 0, 1, 0, 0, 0, 1, 4'd4));
    wr(ADR_EVT + 3, mkEvt(1, 0, 0, 0, 0, 0, 4'b1111, 0, 0, 0, 0, 1, 4'd7));
    wr(ADR_EVT + 4, mkEvt(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd6));
    wr(ADR_MASK + 0, 1 << 6);
    wr(ADR_MASK + 1, 1 << 6);
    wr(ADR_MASK + 2, 1 << 3);
    wr(ADR_MASK + 3, 1 << 3);
    check("R6 masked events idle in state 0", pinOut, 0);
    wr(ADR_MASK + 4, 1);
    check("R10 state before first load", stateOut, 0);
    @(negedge clk);
    check("R10 state loaded 6", stateOut, 6);
    check("R6 no outputs in state 6 yet", pinOut, 0);
    @(negedge clk);
    check("R7 ORed sets", pinOut, 4'b0110);
    check("R10 state loaded 3", stateOut, 3);
    @(negedge clk);
    check("R8 conflict resolution", pinOut, 4'b1011);
    check("R7 irq pulse", irq, 1);
    check("R10 highest event load wins", stateOut, 7);
    @(negedge clk);
    check("R7 irq one cycle", irq, 0);
    idle(3);
    check("R6 no event in state 7", pinOut, 4'b1011);
    check("R10 state holds", stateOut, 7);

    // R9 and R5 timing: start on in1 rise, clear on in3 rise, start+stop on in0 rise
    doReset('0);
    wr(ADR_MATCH + 0, 100);
    wr(ADR_EVT + 0, mkEvt(0, 1, 0, 2'd2, 2'd1, 0, 0, 0, 1, 0, 0, 0, 0));
    wr(ADR_EVT + 1, mkEvt(0, 3, 0, 2'd2, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(ADR_EVT + 2, mkEvt(0, 0, 0, 2'd2, 2'd1, 0, 0, 0, 1, 1, 0, 0, 0));
    wr(ADR_MASK + 0, 1);
    wr(ADR_MASK + 1, 1);
    wr(ADR_MASK + 2, 1);
    idle(3);
    pinIn[1] = 1'b1;
    idle(3);
    check("R5 R9 start on third edge", countOut, 0);
    @(negedge clk);
    check("R9 counting after start", countOut, 1);
    idle(5);
    check("R2 running count", countOut, 6);
    pinIn[3] = 1'b1;
    idle(3);
    check("R9 reset action", countOut, 0);
    @(negedge clk);
    check("R9 still running after reset", countOut, 1);
    pinIn[0] = 1'b1;
    idle(3);
    check("R9 last count before stop", countOut, 4);
    idle(3);
    check("R9 stop wins over start", countOut, 4);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule